// File: doc/BRIEF.md
# Open-Page SDRAM Bank Command Sequencer

This block sits between a request source and an SDRAM command bus. Each request is a read or a write with one flat address. The block splits that address into a bank group, a bank, a row and a column. It remembers which row, if any, is open in each of the 16 banks. It then issues ACTIVATE, READ, WRITE and PRECHARGE commands one at a time on a single command bus.

A request whose row is already open in its bank (a hit) needs only one column command. A request to a bank with a different row open (a miss) first closes that row, then opens the new one, then issues the column command. A request to a closed bank opens the row and then issues the column command.

Every command waits for the minimum spacings. These are 4 clocks from ACTIVATE to a column command, 2 clocks between any two column commands, 2 clocks from READ to PRECHARGE, and 4 clocks from PRECHARGE to ACTIVATE. The block also flags the clocks in which read data is due on the data bus.

Top module: `sdram_bank_seq`

## Requirements
- R1: The request address is {group[29:28], bank[27:26], row[25:10], column[9:0]}. `cmd_bank` is {group, bank}. `cmd_row` carries the row on ACTIVATE. `cmd_col` carries the column on READ and WRITE.
- R2: After reset all banks are closed. `req_ready` is 1, `cmd_valid` is 0 and `rd_due` is 0. The first access to any bank issues ACTIVATE and then the column command, with no PRECHARGE.
- R3: A READ or WRITE to a bank comes at least 4 clocks after the ACTIVATE to that bank.
- R4: A request whose row is already open in its bank issues exactly one column command and no ACTIVATE or PRECHARGE. The command type code is ACTIVATE=0, READ=1, WRITE=2, PRECHARGE=3.
- R5: A request to a bank with a different row open issues PRECHARGE, then ACTIVATE of the new row, then the column command, in that order.
- R6: Any two column commands are at least 2 clocks apart, whatever their banks.
- R7: A PRECHARGE to a bank comes at least 2 clocks after the last READ to that bank.
- R8: An ACTIVATE to a bank comes at least 4 clocks after the last PRECHARGE to that bank.
- R9: `rd_due` is 1 in exactly the clocks 4 through 7 after each READ command, and 0 otherwise.
- R10: The block takes one request at a time. `req_ready` is 0 from the clock after acceptance until the column command has been issued. `req_ready` is 1 again in the clock after that column command.
- R11: Opening or closing a row in one bank leaves the open row of every other bank unchanged. A later request to that other row is a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 30 | Flat address {group, bank, row, column} |
| cmd_valid | output | 1 | A command is issued this clock |
| cmd_type | output | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_bank | output | 4 | Target bank {group, bank} |
| cmd_row | output | 16 | Row of the current request |
| cmd_col | output | 10 | Column of the current request |
| rd_due | output | 1 | Read data beat expected this clock |

## Verification
Each fault in the internal state shows up in a different way at the ports:

- A wrong open-row flag or a wrong stored row shows up on the next request to that bank. The bench sees an extra or missing PRECHARGE or ACTIVATE, or a PRECHARGE where a bare ACTIVATE belonged.
- A spacing counter that expires early shows up as a command issued too soon after the command it depends on. This appears in the same clock the command leaves the block.
- A fault in the read window shifts `rd_due` within 4 to 7 clocks of a READ.
- A stuck busy state freezes `req_ready`, so no further commands appear.

// File: rtl/sdram_bank_seq.sv
`timescale 1ns/1ps
module sdram_bank_seq #(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 16,
  parameter int COL_W = 10,
  parameter int T_RCD = 4,
  parameter int T_CCD = 2,
  parameter int T_RTP = 2,
  parameter int T_RP  = 4,
  parameter int CL    = 4,
  parameter int BURST = 4,
  localparam int BK_W = BG_W + BA_W,
  localparam int AW   = BK_W + ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  output logic             cmd_valid,
  output logic [1:0]       cmd_type,
  output logic [BK_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rd_due
);
  localparam int NBANK = 1 << BK_W;
  localparam int TM1   = (T_RCD > T_CCD) ? T_RCD : T_CCD;
  localparam int TM2   = (T_RTP > T_RP) ? T_RTP : T_RP;
  localparam int TMAX  = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW    = $clog2(TMAX + 1);
  localparam int SRL   = CL + BURST - 1;
  localparam logic [1:0] C_ACT = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_PRE = 2'd3;

  logic             busy, q_wr;
  logic [BK_W-1:0]  q_bank;
  logic [ROW_W-1:0] q_row;
  logic [COL_W-1:0] q_col;
  logic [NBANK-1:0] open_v;
  logic [ROW_W-1:0] open_row [NBANK];
  logic [CW-1:0]    rcd_c [NBANK];
  logic [CW-1:0]    rtp_c [NBANK];
  logic [CW-1:0]    rp_c  [NBANK];
  logic [CW-1:0]    ccd_c;
  logic [SRL-1:0]   rd_sr;
  logic             hit, can;
  logic [1:0]       want_t;

  assign hit = open_v[q_bank] && (open_row[q_bank] == q_row);

  always_comb begin
    if (hit) begin
      want_t = q_wr ? C_WR : C_RD;
      can    = (rcd_c[q_bank] == '0) && (ccd_c == '0);
    end else if (open_v[q_bank]) begin
      want_t = C_PRE;
      can    = (rtp_c[q_bank] == '0);
    end else begin
      want_t = C_ACT;
      can    = (rp_c[q_bank] == '0);
    end
  end

  assign req_ready = !busy;
  assign cmd_valid = busy && can;
  assign cmd_type  = want_t;
  assign cmd_bank  = q_bank;
  assign cmd_row   = q_row;
  assign cmd_col   = q_col;
  assign rd_due    = |rd_sr[SRL-1:CL-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      q_wr   <= 1'b0;
      q_bank <= '0;
      q_row  <= '0;
      q_col  <= '0;
      open_v <= '0;
      ccd_c  <= '0;
      rd_sr  <= '0;
      for (int b = 0; b < NBANK; b++) begin
        open_row[b] <= '0;
        rcd_c[b]    <= '0;
        rtp_c[b]    <= '0;
        rp_c[b]     <= '0;
      end
    end else begin
      rd_sr <= {rd_sr[SRL-2:0], cmd_valid && (cmd_type == C_RD)};
      for (int b = 0; b < NBANK; b++) begin
        if (rcd_c[b] != '0) rcd_c[b] <= rcd_c[b] - 1'b1;
        if (rtp_c[b] != '0) rtp_c[b] <= rtp_c[b] - 1'b1;
        if (rp_c[b]  != '0) rp_c[b]  <= rp_c[b]  - 1'b1;
      end
      if (ccd_c != '0) ccd_c <= ccd_c - 1'b1;
      if (req_valid && !busy) begin
        busy   <= 1'b1;
        q_wr   <= req_write;
        q_bank <= req_addr[AW-1 -: BK_W];
        q_row  <= req_addr[COL_W +: ROW_W];
        q_col  <= req_addr[COL_W-1:0];
      end
      if (cmd_valid) begin
        case (cmd_type)
          C_ACT: begin
            open_v[q_bank]   <= 1'b1;
            open_row[q_bank] <= q_row;
            rcd_c[q_bank]    <= CW'(T_RCD - 1);
          end
          C_PRE: begin
            open_v[q_bank] <= 1'b0;
            rp_c[q_bank]   <= CW'(T_RP - 1);
          end
          C_RD: begin
            rtp_c[q_bank] <= CW'(T_RTP - 1);
            ccd_c         <= CW'(T_CCD - 1);
            busy          <= 1'b0;
          end
          default: begin
            ccd_c <= CW'(T_CCD - 1);
            busy  <= 1'b0;
          end
        endcase
      end
    end
  end

  // Independent elapsed-time trackers for the spacing assertions
  logic [CW-1:0] since_act [NBANK];
  logic [CW-1:0] since_rd  [NBANK];
  logic [CW-1:0] since_pre [NBANK];
  logic [CW-1:0] since_col;
  logic          is_col;
  assign is_col = cmd_valid && (cmd_type == C_RD || cmd_type == C_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_col <= '1;
      for (int b = 0; b < NBANK; b++) begin
        since_act[b] <= '1;
        since_rd[b]  <= '1;
        since_pre[b] <= '1;
      end
    end else begin
      since_col <= is_col ? CW'(1) : ((since_col != '1) ? since_col + 1'b1 : since_col);
      for (int b = 0; b < NBANK; b++) begin
        if (cmd_valid && cmd_bank == BK_W'(b) && cmd_type == C_ACT) since_act[b] <= CW'(1);
        else if (since_act[b] != '1) since_act[b] <= since_act[b] + 1'b1;
        if (cmd_valid && cmd_bank == BK_W'(b) && cmd_type == C_RD) since_rd[b] <= CW'(1);
        else if (since_rd[b] != '1) since_rd[b] <= since_rd[b] + 1'b1;
        if (cmd_valid && cmd_bank == BK_W'(b) && cmd_type == C_PRE) since_pre[b] <= CW'(1);
        else if (since_pre[b] != '1) since_pre[b] <= since_pre[b] + 1'b1;
      end
    end
  end

  p_act_to_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act[cmd_bank] >= CW'(T_RCD));
  p_col_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_col >= CW'(T_CCD));
  p_rd_to_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == C_PRE) |-> since_rd[cmd_bank] >= CW'(T_RTP));
  p_pre_to_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == C_ACT) |-> since_pre[cmd_bank] >= CW'(T_RP));
  p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/test_sdram_bank_seq.sv
`timescale 1ns/1ps
module test_sdram_bank_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [29:0] req_addr = '0;
  logic        req_ready, cmd_valid, rd_due;
  logic [1:0]  cmd_type;
  logic [3:0]  cmd_bank;
  logic [15:0] cmd_row;
  logic [9:0]  cmd_col;

  always #2.5 clk = ~clk;

  sdram_bank_seq i_sdram_bank_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .rd_due(rd_due));

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit done = 0, ready_next = 0;
  logic [31:0] expq [$];
  longint rdq [$];
  bit          mopen [16];
  logic [15:0] mrow  [16];
  longint last_act [16], last_pre [16], last_rd [16];
  longint last_col = -100;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] pk(logic [1:0] t, logic [3:0] b, logic [15:0] r, logic [9:0] c);
    return {t, b, r, c};
  endfunction

  task automatic req(bit w, logic [1:0] bg, logic [1:0] ba, logic [15:0] row, logic [9:0] col);
    logic [3:0] b;
    b = {bg, ba};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = {bg, ba, row, col};
    if (mopen[b] && mrow[b] != row) expq.push_back(pk(2'd3, b, row, col));
    if (!(mopen[b] && mrow[b] == row)) expq.push_back(pk(2'd0, b, row, col));
    expq.push_back(pk(w ? 2'd2 : 2'd1, b, row, col));
    mopen[b] = 1'b1; mrow[b] = row;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      bit expd;
      logic [31:0] e;
      while (rdq.size() > 0 && cyc - rdq[0] > 7) void'(rdq.pop_front());
      expd = 1'b0;
      foreach (rdq[i]) if (cyc - rdq[i] >= 4) expd = 1'b1;
      check(rd_due == expd, "R9 rd_due window", rd_due, expd);
      if (ready_next) begin
        check(req_ready == 1'b1, "R10 ready after column", req_ready, 1);
        ready_next = 0;
      end
      if (cmd_valid) begin
        check(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
        if (expq.size() == 0) begin
          check(0, "R4 unexpected command", cmd_type, -1);
        end else begin
          e = expq.pop_front();
          check(cmd_type == e[31:30], "R5 command order/type", cmd_type, e[31:30]);
          check(cmd_bank == e[29:26], "R1 bank field", cmd_bank, e[29:26]);
          if (cmd_type == 2'd0) check(cmd_row == e[25:10], "R1 row field", cmd_row, e[25:10]);
          if (cmd_type == 2'd1 || cmd_type == 2'd2)
            check(cmd_col == e[9:0], "R1 column field", cmd_col, e[9:0]);
        end
        case (cmd_type)
          2'd0: begin
            check(cyc - last_pre[cmd_bank] >= 4, "R8 PRE to ACT", cyc - last_pre[cmd_bank], 4);
            last_act[cmd_bank] = cyc;
          end
          2'd3: begin
            check(cyc - last_rd[cmd_bank] >= 2, "R7 RD to PRE", cyc - last_rd[cmd_bank], 2);
            last_pre[cmd_bank] = cyc;
          end
          default: begin
            check(cyc - last_act[cmd_bank] >= 4, "R3 ACT to column", cyc - last_act[cmd_bank], 4);
            check(cyc - last_col >= 2, "R6 column spacing", cyc - last_col, 2);
            last_col = cyc;
            ready_next = 1;
            if (cmd_type == 2'd1) begin
              last_rd[cmd_bank] = cyc;
              rdq.push_back(cyc);
            end
          end
        endcase
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      errors++;
      $display("FAIL watchdog R10: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 16; b++) begin
      mopen[b] = 0; mrow[b] = '0;
      last_act[b] = -100; last_pre[b] = -100; last_rd[b] = -100;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 reset ready", req_ready, 1);
    check(cmd_valid == 1'b0, "R2 reset no command", cmd_valid, 0);
    check(rd_due == 1'b0, "R2 reset rd_due", rd_due, 0);

    req(1, 2'd0, 2'd0, 16'h1234, 10'h010);  // R2 closed bank: ACT, WR
    req(0, 2'd0, 2'd0, 16'h1234, 10'h020);  // R4 hit
    req(0, 2'd0, 2'd0, 16'h1234, 10'h021);  // R6 back-to-back hits
    req(0, 2'd0, 2'd0, 16'h5555, 10'h000);  // R5 R7 R8 miss after read
    req(1, 2'd3, 2'd2, 16'hFFFF, 10'h3FF);  // R1 top fields
    req(0, 2'd0, 2'd0, 16'h5555, 10'h001);  // R11 bank0 still open
    req(0, 2'd3, 2'd2, 16'h0000, 10'h002);  // R5 miss after write
    req(0, 2'd3, 2'd2, 16'h0001, 10'h003);  // R8 quick second miss
    req(1, 2'd1, 2'd3, 16'hABCD, 10'h155);  // other group
    req(0, 2'd2, 2'd1, 16'h0F0F, 10'h2AA);
    req(0, 2'd1, 2'd3, 16'hABCD, 10'h156);  // R11 hit after other bank opened
    req(1, 2'd3, 2'd2, 16'h0001, 10'h004);  // R4 hit
    req(0, 2'd0, 2'd0, 16'h5555, 10'h3FE);  // R11 bank0 hit
    for (int i = 0; i < 4; i++) req(0, 2'd2, 2'd1, 16'h0F0F, 10'(i));  // R6 R9 stream

    while (expq.size() > 0) @(negedge clk);
    repeat (12) @(negedge clk);
    check(expq.size() == 0, "R5 all expected commands issued", expq.size(), 0);
    check(rd_due == 1'b0, "R9 rd_due idle", rd_due, 0);
    check(req_ready == 1'b1, "R10 idle ready", req_ready, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule